// File: doc/BRIEF.md
# Configurable Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel. A transmitter turns bytes taken from a valid/ready stream into framed serial bits. A receiver turns the serial line back into bytes on a second valid/ready stream. Both are timed by an oversampling tick input, with `OVS` ticks per bit.

Software describes the frame on an 8-bit format input. The format covers:
- data length, 5 to 8 bits;
- one or two stop bits;
- none, odd, even, mark or space parity;
- one of four line modes.

The format is copied into the active configuration only when a configure command runs. Commands go into an 8-bit command word. Hardware clears that word to zero once the command has completed, and a separate status byte is zero on success and nonzero on a rejected command.

The channel reports sticky receive errors (overrun, parity, framing, break). It also reports which directions are blocked and a registered copy of the four modem inputs. It drives DTR, RTS and a forced break level on the transmit line.

Top module: `serchan_core`

## Requirements
- R1: After reset: serTx is 1, txReady and rxValid are 0, cmdWord and chanStat are 0, errStat is 0, and blockStat is 4'b0011 (both directions disabled). The active format is 8 data bits, 1 stop bit, no parity, normal mode.
- R2: cmdWord loads from cmdData on cmdWr only while it reads zero, and returns to zero when the command completes. Some words are rejected: 0x01 together with 0x02, 0x10 together with 0x20, or 0x40 together with 0x80. A rejected word applies nothing and sets chanStat to 0x01. Any other word sets chanStat to 0x00.
- R3: Command bit 0x10 enables the receiver and 0x20 disables it; 0x40 enables the transmitter and 0x80 disables it. blockStat bit 0 is set while the receiver is disabled and bit 1 while the transmitter is disabled. txReady is 0 while the transmitter is disabled.
- R4: Format bits [1:0] give 5+code data bits and bit 2 gives two stop bits. A transmitted frame is one low start bit, the data LSB first, the optional parity bit, then high stop bits. Each bit lasts OVS ticks.
- R5: Format bits [5:3] pick the parity: 3'b001 odd, 3'b010 even, 3'b100 mark (always 1), 3'b110 space (always 0). Any other code means no parity. Odd and even parity are computed over the data bits in use.
- R6: A received byte appears on rxData with its unused upper bits zero. A parity mismatch sets errStat bit 1 and a low first stop bit sets errStat bit 2. In both cases the byte is still delivered.
- R7: A byte that completes while rxValid is high and rxReady is low is dropped. The held byte is kept unchanged and errStat bit 0 is set.
- R8: A frame with all data bits 0, a 0 parity bit (if parity is on) and a low stop bit is a break. It sets errStat bit 3 and delivers no byte.
- R9: Changing fmtReg has no effect until command 0x01 (whole format) or 0x02 (line mode bits [7:6] only) runs. A configure command waits until no frame is in progress in either direction.
- R10: Format bits [7:6] pick the line mode:
  - 0, normal.
  - 1, echo: serTx repeats serRx, the receiver still delivers, and the transmitter takes no bytes.
  - 2, local loopback: the transmitter feeds the receiver and serTx stays 1.
  - 3, remote loopback: like echo, but nothing is delivered.
- R11: Command bit 0x04 discards the held received byte and clears errStat. Command bit 0x08 aborts a frame being transmitted and returns serTx to 1.
- R12: brkReq forces serTx to 0, and dtrOut and rtsOut follow dtrReq and rtsReq. modemStat is a registered copy of modemIn (bit 0 CTS, bit 1 DSR, bit 2 RI, bit 3 DCD). With ctsFlowEn set and CTS low, no new byte is accepted and blockStat bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oversampling tick, OVS per bit |
| fmtReg | input | 8 | Requested frame format and line mode |
| cmdWr | input | 1 | Write strobe for the command word |
| cmdData | input | 8 | Command to load |
| cmdWord | output | 8 | Pending command, zero when idle |
| chanStat | output | 8 | Result of the last command, nonzero on rejection |
| dtrReq | input | 1 | Requested DTR level |
| rtsReq | input | 1 | Requested RTS level |
| brkReq | input | 1 | Force break on the transmit line |
| ctsFlowEn | input | 1 | Let CTS gate the transmitter |
| modemIn | input | 4 | CTS, DSR, RI, DCD inputs |
| modemStat | output | 4 | Registered modem inputs |
| blockStat | output | 4 | Receiver off, transmitter off, spare, CTS block |
| errStat | output | 4 | Sticky overrun, parity, framing, break |
| dtrOut | output | 1 | DTR line |
| rtsOut | output | 1 | RTS line |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Transmitter accepts txData |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | rxData holds a byte |
| rxReady | input | 1 | Consumer takes rxData |
| serRx | input | 1 | Serial receive line |
| serTx | output | 1 | Serial transmit line |

## Verification
A stale active configuration shows at the ports within one frame: the next frame sampled on serTx has the wrong length, parity bit or stop count. A receiver that holds the wrong bit index or sample phase shows as a wrong rxData value or a spurious errStat bit about one bit time after the stop bit. A command word that never clears holds cmdWord nonzero indefinitely and keeps txReady low. A wrong line mode selection shows within a few cycles: serTx either stops following serRx, or it moves during local loopback.

// File: rtl/serchan_pkg.sv
package serchan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } chanMode_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } parity_e;

  typedef struct packed {
    chanMode_e  mode;
    parity_e    parity;
    logic       twoStop;
    logic [1:0] lenCode;
  } lineCfg_t;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic     rxEn;
    logic     txAllow;
    logic     rxHold;
    logic     flushRx;
    logic     flushTx;
    lineCfg_t cfg;
  } ctlStrobe_t;

  function automatic lineCfg_t decodeFmt(input logic [7:0] f);
    lineCfg_t c;
    c.mode    = chanMode_e'(f[7:6]);
    c.twoStop = f[2];
    c.lenCode = f[1:0];
    case (f[5:3])
      3'b001:  c.parity = PAR_ODD;
      3'b010:  c.parity = PAR_EVEN;
      3'b100:  c.parity = PAR_MARK;
      3'b110:  c.parity = PAR_SPACE;
      default: c.parity = PAR_NONE;
    endcase
    return c;
  endfunction

  function automatic logic parityBit(input logic [7:0] d, input parity_e p);
    case (p)
      PAR_ODD:  return ~(^d);
      PAR_EVEN: return ^d;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/serchan_ctrl.sv
module serchan_ctrl
  import serchan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic [7:0] cmdData,
  input  logic [7:0] fmtReg,
  input  logic       ctsFlowEn,
  input  logic [3:0] modemIn,
  input  logic       txBusy,
  input  logic       rxBusy,
  output ctlStrobe_t ctl,
  output logic [7:0] cmdWord,
  output logic [7:0] chanStat,
  output logic [3:0] blockStat,
  output logic [3:0] modemStat
);

  logic [7:0] cmdQ;
  logic       failQ;
  lineCfg_t   cfgQ;
  logic       rxEnQ;
  logic       txEnQ;
  logic [3:0] modemQ;

  lineCfg_t newCfg;
  logic     cmdBad;
  logic     cfgReq;
  logic     execNow;
  logic     applyNow;
  logic     ctsBlock;
  logic     modeTxOk;

  assign newCfg   = decodeFmt(fmtReg);
  assign cmdBad   = (cmdQ[0] & cmdQ[1]) | (cmdQ[4] & cmdQ[5]) | (cmdQ[6] & cmdQ[7]);
  assign cfgReq   = cmdQ[0] | cmdQ[1];
  assign execNow  = (cmdQ != 8'h00) && (cmdBad || !cfgReq || !(txBusy || rxBusy));
  assign applyNow = execNow && !cmdBad;
  assign ctsBlock = ctsFlowEn && !modemQ[0];
  assign modeTxOk = (cfgQ.mode == MODE_NORMAL) || (cfgQ.mode == MODE_LOCAL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= 8'h00;
      failQ  <= 1'b0;
      cfgQ   <= decodeFmt(8'h03);
      rxEnQ  <= 1'b0;
      txEnQ  <= 1'b0;
      modemQ <= 4'h0;
    end else begin
      modemQ <= modemIn;
      if (cmdQ == 8'h00) begin
        if (cmdWr) cmdQ <= cmdData;
      end else if (execNow) begin
        cmdQ  <= 8'h00;
        failQ <= cmdBad;
        if (!cmdBad) begin
          if (cmdQ[0])      cfgQ      <= newCfg;
          else if (cmdQ[1]) cfgQ.mode <= newCfg.mode;
          if (cmdQ[4]) rxEnQ <= 1'b1;
          if (cmdQ[5]) rxEnQ <= 1'b0;
          if (cmdQ[6]) txEnQ <= 1'b1;
          if (cmdQ[7]) txEnQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    ctl.rxEn    = rxEnQ;
    ctl.rxHold  = cfgReq;
    ctl.txAllow = txEnQ && !cfgReq && !ctsBlock && modeTxOk;
    ctl.flushRx = applyNow && cmdQ[2];
    ctl.flushTx = applyNow && cmdQ[3];
    ctl.cfg     = cfgQ;
  end

  assign cmdWord   = cmdQ;
  assign chanStat  = {7'b0, failQ};
  assign blockStat = {ctsBlock && txEnQ, 1'b0, !txEnQ, !rxEnQ};
  assign modemStat = modemQ;

  // R2: a pending command with both engines idle completes on the next edge
  a_r2_cmd_completes: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != 8'h00 && !txBusy && !rxBusy) |=> (cmdQ == 8'h00));

  // R9: the active format never moves while a frame is in flight
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy || rxBusy) |-> $stable(cfgQ));

endmodule

// File: rtl/serchan_dp.sv
module serchan_dp
  import serchan_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  ctlStrobe_t ctl,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  input  logic       serRx,
  input  logic       brkReq,
  input  logic       dtrReq,
  input  logic       rtsReq,
  output logic       serTx,
  output logic       dtrOut,
  output logic       rtsOut,
  output logic [3:0] errStat,
  output logic       txBusy,
  output logic       rxBusy
);

  localparam int CNT_W   = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int HALF    = OVS / 2;
  localparam int FRAME_W = 12;
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_WAITHI} rxState_e;

  logic [3:0] nData;
  logic       hasPar;
  logic [7:0] dataMask;

  assign nData    = 4'd5 + {2'b00, ctl.cfg.lenCode};
  assign hasPar   = ctl.cfg.parity != PAR_NONE;
  assign dataMask = 8'hFF >> (2'd3 - ctl.cfg.lenCode);

  // ---------------- line synchroniser ----------------
  logic rxS1, rxS2;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxS1 <= 1'b1;
      rxS2 <= 1'b1;
    end else begin
      rxS1 <= serRx;
      rxS2 <= rxS1;
    end
  end

  // ---------------- transmitter ----------------
  logic [FRAME_W-1:0] txShr;
  logic [FRAME_W-1:0] txFrame;
  logic [3:0]         txLeft;
  logic [3:0]         txLen;
  logic [CNT_W-1:0]   txCnt;
  logic               txLine;

  always_comb begin
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nData)) txFrame[1 + i] = txData[i];
    end
    if (hasPar) txFrame[4'd1 + nData] = parityBit(txData & dataMask, ctl.cfg.parity);
    txLen = 4'd1 + nData + {3'b000, hasPar} + (ctl.cfg.twoStop ? 4'd2 : 4'd1);
  end

  assign txBusy  = txLeft != 4'd0;
  assign txReady = !txBusy && ctl.txAllow;
  assign txLine  = txShr[0];

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flushTx) begin
      txShr  <= '1;
      txLeft <= 4'd0;
      txCnt  <= '0;
    end else if (txValid && txReady) begin
      txShr  <= txFrame;
      txLeft <= txLen;
      txCnt  <= '0;
    end else if (txBusy && tickEn) begin
      if (txCnt == BIT_END) begin
        txCnt  <= '0;
        txShr  <= {1'b1, txShr[FRAME_W-1:1]};
        txLeft <= txLeft - 4'd1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // ---------------- receiver ----------------
  rxState_e         rxSt;
  logic [CNT_W-1:0] rxCnt;
  logic [3:0]       rxIdx;
  logic [8:0]       rxBits;
  logic [7:0]       rxDataQ;
  logic             rxValidQ;
  logic [3:0]       errQ;
  logic             rxLine;
  logic [3:0]       lastIdx;
  logic [7:0]       rxWord;
  logic             rxParBit;
  logic             parOk;
  logic             isBreak;

  always_comb begin
    case (ctl.cfg.mode)
      MODE_LOCAL:  rxLine = txLine;
      MODE_REMOTE: rxLine = 1'b1;
      default:     rxLine = rxS2;
    endcase
  end

  assign lastIdx  = nData + {3'b000, hasPar};
  assign rxWord   = rxBits[7:0] & dataMask;
  assign rxParBit = rxBits[nData];
  assign parOk    = !hasPar || (rxParBit == parityBit(rxWord, ctl.cfg.parity));
  assign isBreak  = !rxLine && (rxWord == 8'h00) && (!hasPar || !rxParBit);
  assign rxBusy   = (rxSt == RX_START) || (rxSt == RX_BITS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSt     <= RX_IDLE;
      rxCnt    <= '0;
      rxIdx    <= 4'd0;
      rxBits   <= '0;
      rxDataQ  <= 8'h00;
      rxValidQ <= 1'b0;
      errQ     <= 4'h0;
    end else begin
      if (rxValidQ && rxReady) rxValidQ <= 1'b0;
      if (ctl.flushRx) begin
        rxValidQ <= 1'b0;
        errQ     <= 4'h0;
        rxSt     <= RX_IDLE;
      end else if (!ctl.rxEn) begin
        rxSt <= RX_IDLE;
      end else begin
        case (rxSt)
          RX_IDLE: begin
            if (!ctl.rxHold && !rxLine) begin
              rxSt  <= RX_START;
              rxCnt <= '0;
            end
          end
          RX_START: begin
            if (tickEn) begin
              if (rxCnt == HALF_END) begin
                rxCnt  <= '0;
                rxIdx  <= 4'd0;
                rxBits <= '0;
                rxSt   <= rxLine ? RX_IDLE : RX_BITS;
              end else begin
                rxCnt <= rxCnt + 1'b1;
              end
            end
          end
          RX_BITS: begin
            if (tickEn) begin
              if (rxCnt == BIT_END) begin
                rxCnt <= '0;
                if (rxIdx == lastIdx) begin
                  if (isBreak) begin
                    errQ[3] <= 1'b1;
                  end else begin
                    if (rxValidQ && !rxReady) begin
                      errQ[0] <= 1'b1;
                    end else begin
                      rxDataQ  <= rxWord;
                      rxValidQ <= 1'b1;
                    end
                    if (!parOk)  errQ[1] <= 1'b1;
                    if (!rxLine) errQ[2] <= 1'b1;
                  end
                  rxSt <= rxLine ? RX_IDLE : RX_WAITHI;
                end else begin
                  rxBits[rxIdx] <= rxLine;
                  rxIdx         <= rxIdx + 4'd1;
                end
              end else begin
                rxCnt <= rxCnt + 1'b1;
              end
            end
          end
          default: begin
            if (rxLine) rxSt <= RX_IDLE;
          end
        endcase
      end
    end
  end

  assign rxData  = rxDataQ;
  assign rxValid = rxValidQ;
  assign errStat = errQ;

  // ---------------- line output stage ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      serTx  <= 1'b1;
      dtrOut <= 1'b0;
      rtsOut <= 1'b0;
    end else begin
      dtrOut <= dtrReq;
      rtsOut <= rtsReq;
      if (brkReq)                           serTx <= 1'b0;
      else if (ctl.cfg.mode == MODE_LOCAL)  serTx <= 1'b1;
      else if (ctl.cfg.mode == MODE_NORMAL) serTx <= txLine;
      else                                  serTx <= rxS2;
    end
  end

  // R7: a held byte stays put until it is taken
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !ctl.flushRx) |=> (rxValid && $stable(rxData)));

  // R8: a break never comes with a new byte
  a_r8_break_no_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errStat[3]) |-> !$rose(rxValid));

  // R3: a blocked transmitter does not start a frame
  a_r3_no_start_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !ctl.txAllow) |=> !txBusy);

  // R11: an output flush leaves the transmitter idle
  a_r11_flush_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flushTx |=> (!txBusy && txLine));

endmodule

// File: rtl/serchan_core.sv
module serchan_core
  import serchan_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [7:0] fmtReg,
  input  logic       cmdWr,
  input  logic [7:0] cmdData,
  output logic [7:0] cmdWord,
  output logic [7:0] chanStat,
  input  logic       dtrReq,
  input  logic       rtsReq,
  input  logic       brkReq,
  input  logic       ctsFlowEn,
  input  logic [3:0] modemIn,
  output logic [3:0] modemStat,
  output logic [3:0] blockStat,
  output logic [3:0] errStat,
  output logic       dtrOut,
  output logic       rtsOut,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  input  logic       serRx,
  output logic       serTx
);

  ctlStrobe_t ctl;
  logic       txBusy;
  logic       rxBusy;

  serchan_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWr     (cmdWr),
    .cmdData   (cmdData),
    .fmtReg    (fmtReg),
    .ctsFlowEn (ctsFlowEn),
    .modemIn   (modemIn),
    .txBusy    (txBusy),
    .rxBusy    (rxBusy),
    .ctl       (ctl),
    .cmdWord   (cmdWord),
    .chanStat  (chanStat),
    .blockStat (blockStat),
    .modemStat (modemStat)
  );

  serchan_dp #(.OVS(OVS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .ctl     (ctl),
    .txData  (txData),
    .txValid (txValid),
    .txReady (txReady),
    .rxData  (rxData),
    .rxValid (rxValid),
    .rxReady (rxReady),
    .serRx   (serRx),
    .brkReq  (brkReq),
    .dtrReq  (dtrReq),
    .rtsReq  (rtsReq),
    .serTx   (serTx),
    .dtrOut  (dtrOut),
    .rtsOut  (rtsOut),
    .errStat (errStat),
    .txBusy  (txBusy),
    .rxBusy  (rxBusy)
  );

endmodule

// File: tb/serchan_core_tb.sv
module serchan_core_tb_top;

  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic [7:0] fmtReg = 8'h03;
  logic       cmdWr = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic [7:0] cmdWord, chanStat;
  logic       dtrReq = 1'b0, rtsReq = 1'b0, brkReq = 1'b0, ctsFlowEn = 1'b0;
  logic [3:0] modemIn = 4'h0;
  logic [3:0] modemStat, blockStat, errStat;
  logic       dtrOut, rtsOut;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxReady = 1'b0;
  logic       serRx = 1'b1;
  logic       serTx;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serchan_core #(.OVS(OVS)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expFrame(input logic [7:0] d, input int nb, input int pc,
                                           input bit s2, output int len);
    logic [11:0] f;
    int ones;
    logic p;
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      f[1 + i] = d[i];
      ones += int'(d[i]);
    end
    len = 1 + nb;
    if (pc != 0) begin
      case (pc)
        1: p = (ones % 2) == 0;
        2: p = (ones % 2) == 1;
        3: p = 1'b1;
        default: p = 1'b0;
      endcase
      f[len] = p;
      len++;
    end
    len += s2 ? 2 : 1;
    return f;
  endfunction

  task automatic doCmd(input logic [7:0] c);
    int guard = 0;
    while (cmdWord != 8'h00 && guard < 5000) begin @(negedge clk); guard++; end
    cmdData = c;
    cmdWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0;
    guard = 0;
    while (cmdWord != 8'h00 && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic sendTx(input logic [7:0] d);
    int guard = 0;
    txData = d;
    txValid = 1'b1;
    while (!txReady && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic captureTx(input int len, output logic [11:0] got);
    int guard = 0;
    got = '1;
    while (serTx != 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (OVS / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      got[i] = serTx;
      repeat (OVS) @(negedge clk);
    end
  endtask

  task automatic driveFrame(input logic [11:0] f, input int len);
    for (int i = 0; i < len; i++) begin
      serRx = f[i];
      repeat (OVS) @(negedge clk);
    end
    serRx = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic popRx();
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  task automatic txCase(input string req, input logic [7:0] d, input int nb, input int pc, input bit s2);
    logic [11:0] e, got;
    int len;
    e = expFrame(d, nb, pc, s2, len);
    fork
      sendTx(d);
      captureTx(len, got);
    join
    chk(got == e, req, int'(got), int'(e));
    repeat (OVS) @(negedge clk);
  endtask

  task automatic rxCase(input string req, input logic [7:0] d, input int nb, input int pc,
                        input logic [3:0] expErr);
    logic [11:0] f;
    int len;
    f = expFrame(d, nb, pc, 1'b0, len);
    driveFrame(f, len);
    chk(rxValid == 1'b1, req, int'(rxValid), 1);
    chk(rxData == (d & (8'hFF >> (8 - nb))), req, int'(rxData), int'(d & (8'hFF >> (8 - nb))));
    chk(errStat == expErr, req, int'(errStat), int'(expErr));
    popRx();
  endtask

  task automatic testReset();
    chk(serTx == 1'b1 && txReady == 1'b0 && rxValid == 1'b0, "R1 lines",
        int'({serTx, txReady, rxValid}), 3'b100);
    chk(cmdWord == 8'h00 && chanStat == 8'h00, "R1 cmd", int'(cmdWord), 0);
    chk(blockStat == 4'b0011, "R1 block", int'(blockStat), 3);
    chk(errStat == 4'h0, "R1 err", int'(errStat), 0);
  endtask

  task automatic testEnable();
    cmdData = 8'h50;
    cmdWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0;
    chk(cmdWord == 8'h50, "R2 word held", int'(cmdWord), 'h50);
    @(negedge clk);
    chk(cmdWord == 8'h00, "R2 word cleared", int'(cmdWord), 0);
    chk(chanStat == 8'h00, "R2 ok status", int'(chanStat), 0);
    chk(blockStat == 4'b0000, "R3 enabled", int'(blockStat), 0);
    chk(txReady == 1'b1, "R3 txReady", int'(txReady), 1);
  endtask

  task automatic testTxFormats();
    txCase("R4 8N1", 8'hA5, 8, 0, 1'b0);
    fmtReg = 8'h16;
    doCmd(8'h01);
    txCase("R5 7E2", 8'h5B, 7, 2, 1'b1);
    fmtReg = 8'h23;
    doCmd(8'h01);
    txCase("R5 mark", 8'h00, 8, 3, 1'b0);
    fmtReg = 8'h33;
    doCmd(8'h01);
    txCase("R5 space", 8'hFF, 8, 4, 1'b0);
    fmtReg = 8'h09;
    doCmd(8'h01);
    txCase("R5 odd 6bit", 8'h2C, 6, 1, 1'b0);
    fmtReg = 8'h03;
    doCmd(8'h01);
  endtask

  task automatic testRx();
    logic [11:0] f;
    int len;
    rxCase("R6 8N1", 8'h3C, 8, 0, 4'h0);
    fmtReg = 8'h00;
    doCmd(8'h01);
    rxCase("R6 5bit", 8'hF5, 5, 0, 4'h0);
    fmtReg = 8'h0B;
    doCmd(8'h01);
    f = expFrame(8'h01, 8, 1, 1'b0, len);
    f[9] = ~f[9];
    driveFrame(f, len);
    chk(rxValid && rxData == 8'h01, "R6 parity byte", int'(rxData), 1);
    chk(errStat == 4'b0010, "R6 parity err", int'(errStat), 2);
    doCmd(8'h04);
    chk(rxValid == 1'b0 && errStat == 4'h0, "R11 flush in", int'({rxValid, errStat}), 0);
    fmtReg = 8'h03;
    doCmd(8'h01);
    f = expFrame(8'h81, 8, 0, 1'b0, len);
    f[9] = 1'b0;
    driveFrame(f, len);
    chk(rxValid && rxData == 8'h81, "R6 framing byte", int'(rxData), 'h81);
    chk(errStat == 4'b0100, "R6 framing err", int'(errStat), 4);
    doCmd(8'h04);
  endtask

  task automatic testBreakOverrun();
    serRx = 1'b0;
    repeat (12 * OVS) @(negedge clk);
    serRx = 1'b1;
    repeat (8) @(negedge clk);
    chk(errStat == 4'b1000, "R8 break flag", int'(errStat), 8);
    chk(rxValid == 1'b0, "R8 no byte", int'(rxValid), 0);
    doCmd(8'h04);
    rxCase("R7 first", 8'h11, 8, 0, 4'h0);
    begin
      logic [11:0] f;
      int len;
      f = expFrame(8'h22, 8, 0, 1'b0, len);
      driveFrame(f, len);
      f = expFrame(8'h33, 8, 0, 1'b0, len);
      driveFrame(f, len);
    end
    chk(rxValid && rxData == 8'h22, "R7 kept", int'(rxData), 'h22);
    chk(errStat == 4'b0001, "R7 overrun", int'(errStat), 1);
    popRx();
    doCmd(8'h04);
  endtask

  task automatic testBadCmd();
    doCmd(8'h30);
    chk(chanStat == 8'h01, "R2 reject", int'(chanStat), 1);
    chk(blockStat == 4'b0000, "R2 nothing applied", int'(blockStat), 0);
    doCmd(8'h03);
    chk(chanStat == 8'h01, "R2 reject cfg pair", int'(chanStat), 1);
    doCmd(8'h10);
    chk(chanStat == 8'h00, "R2 ok after reject", int'(chanStat), 0);
  endtask

  task automatic testCfgGate();
    logic [11:0] got, e;
    int len;
    fmtReg = 8'h00;
    repeat (4) @(negedge clk);
    txCase("R9 no cfg", 8'hA5, 8, 0, 1'b0);
    doCmd(8'h02);
    txCase("R9 mode only", 8'hA5, 8, 0, 1'b0);
    fmtReg = 8'h03;
    e = expFrame(8'hF0, 8, 0, 1'b0, len);
    fork
      sendTx(8'hF0);
      captureTx(len, got);
      begin
        repeat (40) @(negedge clk);
        fmtReg = 8'h00;
        cmdData = 8'h01;
        cmdWr = 1'b1;
        @(negedge clk);
        cmdWr = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmdWord == 8'h01, "R9 waits busy", int'(cmdWord), 1);
      end
    join
    chk(got == e, "R9 old format kept", int'(got), int'(e));
    doCmd(8'h00);
    txCase("R9 new format", 8'h1F, 5, 0, 1'b0);
    fmtReg = 8'h03;
    doCmd(8'h01);
  endtask

  task automatic testModes();
    logic [11:0] got, e, f;
    int len, zeros;
    fmtReg = 8'h83;
    doCmd(8'h02);
    zeros = 0;
    fork
      sendTx(8'h6E);
      for (int i = 0; i < 12 * OVS; i++) begin
        @(negedge clk);
        if (serTx == 1'b0) zeros++;
      end
    join
    chk(zeros == 0, "R10 local mark", zeros, 0);
    chk(rxValid && rxData == 8'h6E, "R10 local rx", int'(rxData), 'h6E);
    popRx();
    fmtReg = 8'h43;
    doCmd(8'h02);
    chk(txReady == 1'b0, "R10 echo no tx", int'(txReady), 0);
    f = expFrame(8'h99, 8, 0, 1'b0, len);
    fork
      driveFrame(f, len);
      captureTx(len, got);
    join
    chk(got == f, "R10 echo line", int'(got), int'(f));
    chk(rxValid && rxData == 8'h99, "R10 echo rx", int'(rxData), 'h99);
    popRx();
    fmtReg = 8'hC3;
    doCmd(8'h02);
    e = expFrame(8'h42, 8, 0, 1'b0, len);
    fork
      driveFrame(e, len);
      captureTx(len, got);
    join
    chk(got == e, "R10 remote line", int'(got), int'(e));
    chk(rxValid == 1'b0, "R10 remote no rx", int'(rxValid), 0);
    fmtReg = 8'h03;
    doCmd(8'h02);
  endtask

  task automatic testFlushTx();
    sendTx(8'h00);
    repeat (40) @(negedge clk);
    chk(serTx == 1'b0, "R11 frame running", int'(serTx), 0);
    doCmd(8'h08);
    repeat (3) @(negedge clk);
    chk(serTx == 1'b1 && txReady == 1'b1, "R11 tx aborted", int'({serTx, txReady}), 3);
  endtask

  task automatic testModem();
    brkReq = 1'b1;
    dtrReq = 1'b1;
    rtsReq = 1'b0;
    modemIn = 4'b1010;
    repeat (3) @(negedge clk);
    chk(serTx == 1'b0, "R12 break", int'(serTx), 0);
    chk(dtrOut == 1'b1 && rtsOut == 1'b0, "R12 dtr rts", int'({dtrOut, rtsOut}), 2);
    chk(modemStat == 4'b1010, "R12 modem stat", int'(modemStat), 'hA);
    brkReq = 1'b0;
    ctsFlowEn = 1'b1;
    repeat (3) @(negedge clk);
    chk(serTx == 1'b1, "R12 break released", int'(serTx), 1);
    chk(txReady == 1'b0 && blockStat == 4'b1000, "R12 cts block",
        int'({txReady, blockStat}), 8);
    modemIn = 4'b1011;
    repeat (3) @(negedge clk);
    chk(txReady == 1'b1 && blockStat == 4'b0000, "R12 cts open",
        int'({txReady, blockStat}), 'h10);
    ctsFlowEn = 1'b0;
    doCmd(8'hA0);
    chk(blockStat == 4'b0011 && txReady == 1'b0, "R3 disabled", int'(blockStat), 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testTxFormats();
    testRx();
    testBreakOverrun();
    testBadCmd();
    testCfgGate();
    testModes();
    testFlushTx();
    testModem();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule